// File: doc/BRIEF.md
# USB Device Interrupt Status and Control Registers

This block holds two 16-bit registers of a full-speed USB device controller: a status word of latched event flags, and a control word of per-event enables plus the power and reset control levels. The protocol engine reports bus events as one-cycle strobes. Each strobe sets a sticky flag. Firmware acknowledges a flag by writing a word in which that bit is zero. A single interrupt request goes high when any flag is set and its enable bit is also set.

The low bits of the status word identify the last completed transfer: the direction bit and the endpoint number. They are captured whenever the correct-transfer strobe fires and are read-only from the bus. The low control bits leave the block as plain levels, which drive resume signalling, forced suspend, low-power mode, transceiver power-down and a forced bus reset. The register port is a plain single-cycle bus with a byte address, a read enable, a write enable and 16-bit data. Write data takes effect on the clock edge. Read data appears one cycle after the read strobe and holds until the next read. The port has no back-pressure, so every access completes in one cycle.

Top module: `usb_int_ctl_regs`

## Requirements
- R1: After reset the status word reads 0x0000, the control word reads 0x0003 (force-reset and power-down set, all enables clear), and `irq` is low.
- R2: An event strobe on `evt[i]` sets status bit 8+i. The strobe order is: evt[7] correct transfer, evt[6] buffer overrun/underrun, evt[5] error, evt[4] wakeup, evt[3] suspend, evt[2] bus reset, evt[1] start of frame, evt[0] expected start of frame. The flag stays set until firmware clears it.
- R3: A write to the status word clears each flag in bits 15:8 whose write bit is 0, and leaves each flag whose write bit is 1 unchanged. Writing 0xFFFF therefore changes nothing.
- R4: When an event strobe and a clearing write hit the same flag in one cycle, the flag ends set.
- R5: Status bit 4 (direction, 1 = device-to-host) and bits 3:0 (endpoint number) load from `xfer_dir`/`xfer_ep` in each cycle where evt[7] is high. Bus writes never change them. Status bits 7:5 read as zero.
- R6: A write to the control word stores bits 15:8 and 4:0. Bits 7:5 read as zero.
- R7: Control bits 4..0 appear on `resume_req`, `force_suspend`, `low_power`, `phy_pdwn` and `force_bus_rst`, respectively.
- R8: `irq` is high exactly when some status bit 15:8 and the control bit at the same position are both set.
- R9: The control word sits at byte offset 0x40 and the status word at 0x44. Reads of any other offset return zero, and writes to any other offset change nothing.
- R10: `rdata` updates only on the clock edge that samples `rd_en`, and it returns the register value from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| evt | input | 8 | One-cycle event strobes from the protocol engine |
| xfer_dir | input | 1 | Direction of the completing transfer |
| xfer_ep | input | 4 | Endpoint of the completing transfer |
| irq | output | 1 | Combined, enabled interrupt request |
| resume_req | output | 1 | Resume signalling request |
| force_suspend | output | 1 | Forced suspend |
| low_power | output | 1 | Low-power mode select |
| phy_pdwn | output | 1 | Transceiver power-down |
| force_bus_rst | output | 1 | Forced USB reset |

## Verification
The bench writes 0xFFFF to a populated status word. A design that treated written ones as set or toggle would corrupt flags or raise new ones. It clears one flag at a time and checks that the others survive. A design that stored the write data directly would drop them. It fires a strobe in the same cycle as a clearing write, where a clear-priority design would lose the event. It also writes over the identity field, enables masks around a pending flag so the interrupt must follow the mask alone, and targets an unmapped offset, which a loosely decoded design would alias onto a real register.

// File: rtl/usb_icr_pkg.sv
package usb_icr_pkg;
  localparam int REG_W    = 16;
  localparam int N_EVT    = 8;
  localparam int EVT_LSB  = 8;
  localparam int EP_W     = 4;
  localparam int LO_W     = 5;
  localparam int ADDR_W   = 8;
  localparam int DIR_POS  = EP_W;
  localparam int ID_W     = EP_W + 1;
  localparam int XFER_IDX = N_EVT - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h44;

  localparam logic [LO_W-1:0] LO_RESET = 5'b00011;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_icr_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int EW = EP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_i,
  input  logic          dir_i,
  input  logic [EW-1:0] ep_i,
  input  logic          clr_en_i,
  input  logic [NE-1:0] keep_i,
  output logic [NE-1:0] flags_o,
  output logic [EW:0]   id_o
);
  localparam int XI = NE - 1;

  for (genvar i = 0; i < NE; i++) begin : g_flag
    logic held;
    always_comb held = clr_en_i ? (flags_o[i] & keep_i[i]) : flags_o[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[i] <= 1'b0;
      else        flags_o[i] <= held | evt_i[i];
    end

    assert_evt_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flags_o[i]);
    assert_clear_works_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && !keep_i[i] && !evt_i[i]) |=> !flags_o[i]);
    assert_keep_on_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && (!clr_en_i || keep_i[i])) |=> flags_o[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        id_o <= '0;
    else if (evt_i[XI]) id_o <= {dir_i, ep_i};
  end

  assert_id_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i[XI] |=> $stable(id_o));
endmodule

// File: rtl/usb_ctl_reg.sv
module usb_ctl_reg
  import usb_icr_pkg::*;
#(
  parameter int NE = N_EVT,
  parameter int LW = LO_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [NE-1:0] mask_d_i,
  input  logic [LW-1:0] lo_d_i,
  output logic [NE-1:0] mask_o,
  output logic [LW-1:0] lo_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      lo_o   <= LO_RESET;
    end else if (wr_i) begin
      mask_o <= mask_d_i;
      lo_o   <= lo_d_i;
    end
  end

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable({mask_o, lo_o}));
endmodule

// File: rtl/usb_irq_merge.sv
module usb_irq_merge
  import usb_icr_pkg::*;
#(
  parameter int NE = N_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] flags_i,
  input  logic [NE-1:0] mask_i,
  output logic          irq_o
);
  logic [NE-1:0] live;
  always_comb begin
    live  = flags_i & mask_i;
    irq_o = |live;
  end

  assert_no_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !irq_o);
  assert_no_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i == '0) |-> !irq_o);
endmodule

// File: rtl/usb_int_ctl_regs.sv
module usb_int_ctl_regs
  import usb_icr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic [N_EVT-1:0]  evt,
  input  logic              xfer_dir,
  input  logic [EP_W-1:0]   xfer_ep,
  output logic              irq,
  output logic              resume_req,
  output logic              force_suspend,
  output logic              low_power,
  output logic              phy_pdwn,
  output logic              force_bus_rst
);
  reg_sel_e            sel;
  logic [N_EVT-1:0]    flags;
  logic [N_EVT-1:0]    mask;
  logic [LO_W-1:0]     lo;
  logic [ID_W-1:0]     id;
  logic [REG_W-1:0]    ctrl_word, stat_word, rd_mux;
  logic                unused_wbits;

  always_comb begin
    unique case (addr)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_STAT: sel = SEL_STAT;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb unused_wbits = ^wdata[EVT_LSB-1:LO_W];

  usb_evt_flags #(.NE(N_EVT), .EW(EP_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt),
    .dir_i    (xfer_dir),
    .ep_i     (xfer_ep),
    .clr_en_i (wr_en && sel == SEL_STAT),
    .keep_i   (wdata[REG_W-1:EVT_LSB]),
    .flags_o  (flags),
    .id_o     (id)
  );

  usb_ctl_reg #(.NE(N_EVT), .LW(LO_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_en && sel == SEL_CTRL),
    .mask_d_i (wdata[REG_W-1:EVT_LSB]),
    .lo_d_i   (wdata[LO_W-1:0]),
    .mask_o   (mask),
    .lo_o     (lo)
  );

  usb_irq_merge #(.NE(N_EVT)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags),
    .mask_i  (mask),
    .irq_o   (irq)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[REG_W-1:EVT_LSB] = mask;
    ctrl_word[LO_W-1:0]        = lo;
    stat_word = '0;
    stat_word[REG_W-1:EVT_LSB] = flags;
    stat_word[ID_W-1:0]        = id;
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_word;
      SEL_STAT: rd_mux = stat_word;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  always_comb begin
    resume_req    = lo[4];
    force_suspend = lo[3];
    low_power     = lo[2];
    phy_pdwn      = lo[1];
    force_bus_rst = lo[0];
  end

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE && evt == '0) |=> $stable({mask, lo, flags, id}));
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[EVT_LSB-1:ID_W] == '0);
endmodule

// File: tb/sim_usb_int_ctl_regs.sv
module sim_usb_int_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam logic [7:0] A_OTHER = 8'h48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  evt = '0;
  logic        xfer_dir = 1'b0;
  logic [3:0]  xfer_ep = '0;
  logic        irq, resume_req, force_suspend, low_power, phy_pdwn, force_bus_rst;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_int_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt(evt), .xfer_dir(xfer_dir),
    .xfer_ep(xfer_ep), .irq(irq), .resume_req(resume_req),
    .force_suspend(force_suspend), .low_power(low_power),
    .phy_pdwn(phy_pdwn), .force_bus_rst(force_bus_rst)
  );

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string t);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h expected=%h", t, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_evt(input logic do_wr, input logic [7:0] a, input logic [15:0] d,
                        input logic [7:0] ev, input logic dir, input logic [3:0] ep);
    @(negedge clk);
    wr_en = do_wr; addr = a; wdata = d;
    evt = ev; xfer_dir = dir; xfer_ep = ep;
    @(negedge clk);
    wr_en = 1'b0; evt = '0; xfer_dir = 1'b0; xfer_ep = '0;
  endtask

  function automatic logic [15:0] outs();
    return {11'd0, resume_req, force_suspend, low_power, phy_pdwn, force_bus_rst};
  endfunction

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(outs(), 16'h0003, "R1 control outputs after reset");
    chk({15'd0, irq}, 16'h0, "R1 irq after reset");
    rd(A_CTRL, 16'h0003, "R1 control word reset value");
    rd(A_STAT, 16'h0000, "R1 status word reset value");

    wr_evt(1'b0, A_STAT, 16'h0, 8'h01, 1'b0, 4'h0);
    rd(A_STAT, 16'h0100, "R2 expected-frame strobe sets bit 8");
    chk({15'd0, irq}, 16'h0, "R8 irq low with masks clear");

    wr_evt(1'b0, A_STAT, 16'h0, 8'h80, 1'b1, 4'h5);
    rd(A_STAT, 16'h8115, "R2 R5 transfer flag and identity capture");

    wr_evt(1'b1, A_STAT, 16'hFFFF, 8'h00, 1'b0, 4'h0);
    rd(A_STAT, 16'h8115, "R3 writing all ones changes nothing");

    wr_evt(1'b1, A_STAT, 16'h7FFF, 8'h00, 1'b0, 4'h0);
    rd(A_STAT, 16'h0115, "R3 zero clears only bit 15");

    wr_evt(1'b1, A_STAT, 16'h00E0, 8'h00, 1'b0, 4'h0);
    rd(A_STAT, 16'h0015, "R5 identity field ignores writes");

    wr_evt(1'b1, A_STAT, 16'h0000, 8'h08, 1'b0, 4'h0);
    rd(A_STAT, 16'h0815, "R4 event wins over same-cycle clear");

    wr_evt(1'b1, A_CTRL, 16'hFFFF, 8'h00, 1'b0, 4'h0);
    rd(A_CTRL, 16'hFF1F, "R6 control stores 15:8 and 4:0 only");
    chk(outs(), 16'h001F, "R7 control level outputs all set");
    chk({15'd0, irq}, 16'h1, "R8 irq with suspend flag enabled");

    wr_evt(1'b1, A_CTRL, 16'h0700, 8'h00, 1'b0, 4'h0);
    chk(outs(), 16'h0000, "R7 control level outputs cleared");
    chk({15'd0, irq}, 16'h0, "R8 suspend flag masked off");
    wr_evt(1'b0, A_STAT, 16'h0, 8'h02, 1'b0, 4'h0);
    chk({15'd0, irq}, 16'h1, "R8 start-of-frame flag enabled");

    wr_evt(1'b1, A_OTHER, 16'h0000, 8'h00, 1'b0, 4'h0);
    rd(A_OTHER, 16'h0000, "R9 unmapped offset reads zero");
    rd(A_STAT, 16'h0A15, "R9 unmapped write leaves status");
    rd(A_CTRL, 16'h0700, "R9 unmapped write leaves control");

    // same-cycle read and write: read returns pre-write value
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = A_STAT; wdata = 16'h0000;
    exp_q.push_back(16'h0A15); tag_q.push_back("R10 read sees value before write");
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    chk(rdata, 16'h0A15, "R10 rdata holds without a read");
    rd(A_STAT, 16'h0015, "R3 full clear keeps identity");
    chk({15'd0, irq}, 16'h0, "R8 irq drops after clear");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule